// File: doc/BRIEF.md
# Fused Multiply-Add Significand Datapath

This block is the arithmetic heart of a single-precision fused multiply-add unit. It receives three finite, already normalised operands (sign, unbiased exponent and 24-bit significand with its leading one present), forms the exact product of the first two and combines it with the third. Whether the product is added or subtracted depends on a negate flag. It does no rounding. Its result is a sign, a wide signed exponent and a 27-bit significand: the leading one, 23 fraction bits, then guard, round and sticky bits. A later rounding and packing stage consumes that result.

All intermediate work is done in a 64-bit word that holds the leading one at bit 62. The product and the addend are placed in this word. The operand with the smaller exponent is shifted right, and every bit shifted out is folded into the lowest bit. The two words are then summed, or the smaller magnitude is subtracted from the larger. A sum is renormalised by one right step. A difference is renormalised with a leading-zero count and one left shift. An addend flagged as zero skips the combine step. An exact cancellation yields a zero whose sign follows the rounding mode.

The block takes one operation while it is idle. The result appears one cycle later and is held until the consumer takes it.

Top module: `fma_sig_core`

## Requirements
- R1: `in_ready` is high exactly when no result is held. An accepted operation raises `out_valid` on the next clock edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `res_sign`, `res_exp` and `res_sig` stay unchanged.
- R2: The 48-bit product of `x_sig` and `y_sig` is placed in bits 63..16 of a 64-bit word, with product exponent `x_exp + y_exp`. If bit 63 of that word is set, the word moves right by one and the exponent gains one.
- R3: When `z_is_zero` is high, the result is the product word reduced by a jamming right shift of 36. Its exponent is the product exponent and its sign is the product sign.
- R4: The product sign is `x_sign ^ y_sign ^ neg_prod`.
- R5: The addend significand is placed with its leading one at bit 62. The word with the smaller exponent is shifted right by the exponent difference, and the OR of all bits shifted out is merged into bit 0. A difference of 64 or more leaves only that OR bit. The common exponent is the larger of the two.
- R6: With equal product and addend signs, the words are added. A carry into bit 63 causes a one-bit jamming right shift and an exponent increment.
- R7: With unequal signs, the smaller word is subtracted from the larger. The result takes the sign of the larger word, and the addend's sign when the words are equal.
- R8: An exact zero difference gives `res_sig = 0` and `res_exp = 0`. `res_sign` is 1 only when `rmode` is 2'b11 (toward minus infinity). The other codes are 2'b00 nearest, 2'b01 toward zero and 2'b10 toward plus infinity.
- R9: A nonzero difference is shifted left until bit 62 is set, with the exponent lowered by the shift distance. Every nonzero result therefore has `res_sig[26]` set.
- R10: `res_sig` is the final word shifted right by 36, with bit 0 also set if any of the 36 discarded bits was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block idle, operation taken when valid |
| x_sign | input | 1 | Multiplicand sign |
| x_exp | input | EXP_W | Multiplicand unbiased exponent, signed |
| x_sig | input | SIG_W | Multiplicand significand, leading one at top |
| y_sign | input | 1 | Multiplier sign |
| y_exp | input | EXP_W | Multiplier unbiased exponent, signed |
| y_sig | input | SIG_W | Multiplier significand |
| z_sign | input | 1 | Addend sign |
| z_exp | input | EXP_W | Addend unbiased exponent, signed |
| z_sig | input | SIG_W | Addend significand |
| z_is_zero | input | 1 | Addend is zero, product passes alone |
| neg_prod | input | 1 | Subtract the product instead of adding it |
| rmode | input | 2 | Rounding mode code, 2'b11 = toward minus infinity |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W+2 | Result exponent, signed |
| res_sig | output | SIG_W+3 | Result significand with guard, round and sticky bits |

## Verification
Assertions check the handshake on every cycle: acceptance leads to a valid result, and a held result does not move. They also check, for each operation, that the product word has its leading one at bit 62, that a result from normalised inputs has its top bit set or is zero, and that a zero result is negative only under the minus-infinity mode. Exact values cannot be shown by a property. These include the exponent after alignment, carry and left normalisation, and the jammed sticky bit. The bench shows them by sweeping exponent differences, sign and negate combinations and significand patterns, and comparing each result against a bit-serial arithmetic model.

// File: rtl/fma_pkg.sv
package fma_pkg;

  localparam int WORD_W = 64;
  localparam int LEAD   = 62;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  // Right shift that ORs every discarded bit into bit 0.
  function automatic logic [WORD_W-1:0] shr_jam(input logic [WORD_W-1:0] v,
                                                input int unsigned n);
    logic [WORD_W-1:0] lost_mask;
    if (n == 0) return v;
    if (n >= WORD_W) return {{(WORD_W-1){1'b0}}, |v};
    lost_mask = ~({WORD_W{1'b1}} << n);
    return (v >> n) | {{(WORD_W-1){1'b0}}, |(v & lost_mask)};
  endfunction

  // Number of zero bits above the highest set bit.
  function automatic int unsigned lead_zeros(input logic [WORD_W-1:0] v);
    int unsigned cnt;
    cnt = WORD_W;
    for (int i = 0; i < WORD_W; i++) begin
      if (v[i]) cnt = WORD_W - 1 - i;
    end
    return cnt;
  endfunction

  // Clamp a non-negative exponent gap to the word width.
  function automatic int unsigned gap_amount(input int gap);
    if (gap >= WORD_W) return WORD_W;
    if (gap <= 0) return 0;
    return gap;
  endfunction

endpackage

// File: rtl/fma_prod_norm.sv
module fma_prod_norm #(
  parameter int SIG_W = 24,
  parameter int EXP_W = 10,
  parameter int EI_W  = EXP_W + 2
) (
  input  logic                          x_sign,
  input  logic signed [EXP_W-1:0]       x_exp,
  input  logic [SIG_W-1:0]              x_sig,
  input  logic                          y_sign,
  input  logic signed [EXP_W-1:0]       y_exp,
  input  logic [SIG_W-1:0]              y_sig,
  input  logic                          neg_prod,
  output logic [fma_pkg::WORD_W-1:0]    p_word,
  output logic signed [EI_W-1:0]        p_exp,
  output logic                          p_sign,
  output logic                          p_wide
);
  localparam int WORD_W = fma_pkg::WORD_W;
  localparam int PROD_W = 2 * SIG_W;
  localparam int PAD    = WORD_W - PROD_W;

  logic [PROD_W-1:0]       prod;
  logic [WORD_W-1:0]       raw;
  logic signed [EI_W-1:0]  xe_w, ye_w;

  assign prod = x_sig * y_sig;
  assign raw  = {prod, {PAD{1'b0}}};
  assign xe_w = {{(EI_W-EXP_W){x_exp[EXP_W-1]}}, x_exp};
  assign ye_w = {{(EI_W-EXP_W){y_exp[EXP_W-1]}}, y_exp};

  // Product of two values in [1,2) lies in [1,4): at most one step right.
  assign p_wide = raw[WORD_W-1];
  assign p_word = p_wide ? (raw >> 1) : raw;
  assign p_exp  = xe_w + ye_w + {{(EI_W-1){1'b0}}, p_wide};
  assign p_sign = x_sign ^ y_sign ^ neg_prod;

endmodule

// File: rtl/fma_align.sv
module fma_align #(
  parameter int EI_W = 12
) (
  input  logic [fma_pkg::WORD_W-1:0] p_word,
  input  logic signed [EI_W-1:0]     p_exp,
  input  logic [fma_pkg::WORD_W-1:0] z_word,
  input  logic signed [EI_W-1:0]     z_exp,
  output logic [fma_pkg::WORD_W-1:0] p_al,
  output logic [fma_pkg::WORD_W-1:0] z_al,
  output logic signed [EI_W-1:0]     c_exp,
  output logic                       p_moved,
  output logic                       z_moved
);
  int gap;

  always_comb begin
    gap     = int'(z_exp) - int'(p_exp);
    p_al    = p_word;
    z_al    = z_word;
    c_exp   = p_exp;
    p_moved = 1'b0;
    z_moved = 1'b0;
    if (gap > 0) begin
      p_al    = fma_pkg::shr_jam(p_word, fma_pkg::gap_amount(gap));
      c_exp   = z_exp;
      p_moved = 1'b1;
    end else if (gap < 0) begin
      z_al    = fma_pkg::shr_jam(z_word, fma_pkg::gap_amount(-gap));
      c_exp   = p_exp;
      z_moved = 1'b1;
    end
  end

endmodule

// File: rtl/fma_addnorm.sv
module fma_addnorm #(
  parameter int EI_W  = 12,
  parameter int OUT_W = 27
) (
  input  logic                       p_sign,
  input  logic                       z_sign,
  input  logic [fma_pkg::WORD_W-1:0] p_al,
  input  logic [fma_pkg::WORD_W-1:0] z_al,
  input  logic signed [EI_W-1:0]     c_exp,
  input  logic                       rm_down,
  output logic                       r_sign,
  output logic signed [EI_W-1:0]     r_exp,
  output logic [OUT_W-1:0]           r_sig,
  output logic                       ev_carry,
  output logic                       ev_cancel
);
  localparam int WORD_W = fma_pkg::WORD_W;
  localparam int TAIL   = fma_pkg::LEAD - (OUT_W - 1);
  localparam int TOPGAP = WORD_W - 1 - fma_pkg::LEAD;

  logic [WORD_W-1:0] sum, diff, word, squeezed;
  logic              same;
  int unsigned       lsh;

  always_comb begin
    same      = (p_sign == z_sign);
    sum       = z_al + p_al;
    diff      = '0;
    word      = '0;
    lsh       = 0;
    r_sign    = z_sign;
    r_exp     = c_exp;
    ev_carry  = 1'b0;
    ev_cancel = 1'b0;
    if (same) begin
      ev_carry = sum[WORD_W-1];
      word     = ev_carry ? fma_pkg::shr_jam(sum, 1) : sum;
      r_exp    = c_exp + {{(EI_W-1){1'b0}}, ev_carry};
    end else begin
      if (z_al >= p_al) begin
        diff   = z_al - p_al;
        r_sign = z_sign;
      end else begin
        diff   = p_al - z_al;
        r_sign = p_sign;
      end
      ev_cancel = (diff == '0);
      if (!ev_cancel) begin
        lsh   = fma_pkg::lead_zeros(diff) - TOPGAP;
        word  = diff << lsh;
        r_exp = c_exp - $signed(EI_W'(lsh));
      end
    end
    squeezed = fma_pkg::shr_jam(word, TAIL);
    r_sig    = squeezed[OUT_W-1:0];
    if (ev_cancel) begin
      r_sign = rm_down;
      r_exp  = '0;
      r_sig  = '0;
    end
  end

endmodule

// File: rtl/fma_sig_core.sv
module fma_sig_core #(
  parameter int SIG_W = 24,
  parameter int EXP_W = 10,
  parameter int GRS_W = 3,
  parameter int EI_W  = EXP_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     x_sign,
  input  logic signed [EXP_W-1:0]  x_exp,
  input  logic [SIG_W-1:0]         x_sig,
  input  logic                     y_sign,
  input  logic signed [EXP_W-1:0]  y_exp,
  input  logic [SIG_W-1:0]         y_sig,
  input  logic                     z_sign,
  input  logic signed [EXP_W-1:0]  z_exp,
  input  logic [SIG_W-1:0]         z_sig,
  input  logic                     z_is_zero,
  input  logic                     neg_prod,
  input  logic [1:0]               rmode,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     res_sign,
  output logic signed [EI_W-1:0]   res_exp,
  output logic [SIG_W+GRS_W-1:0]   res_sig
);
  localparam int WORD_W = fma_pkg::WORD_W;
  localparam int OUT_W  = SIG_W + GRS_W;
  localparam int TAIL   = fma_pkg::LEAD - (OUT_W - 1);
  localparam int ZSH    = fma_pkg::LEAD - (SIG_W - 1);

  // Named internal events, visible to the assertions below.
  logic [WORD_W-1:0]       p_word, z_word, p_al, z_al, p_squeezed;
  logic signed [EI_W-1:0]  p_exp, z_exp_w, c_exp, an_exp, nx_exp;
  logic                    p_sign, p_wide, p_moved, z_moved;
  logic                    an_sign, ev_carry, ev_cancel, nx_sign;
  logic [OUT_W-1:0]        an_sig, nx_sig;
  logic                    accept, release_res;

  fma_prod_norm #(.SIG_W(SIG_W), .EXP_W(EXP_W), .EI_W(EI_W)) u_prod (
    .x_sign(x_sign), .x_exp(x_exp), .x_sig(x_sig),
    .y_sign(y_sign), .y_exp(y_exp), .y_sig(y_sig),
    .neg_prod(neg_prod),
    .p_word(p_word), .p_exp(p_exp), .p_sign(p_sign), .p_wide(p_wide)
  );

  assign z_word  = WORD_W'(z_sig) << ZSH;
  assign z_exp_w = {{(EI_W-EXP_W){z_exp[EXP_W-1]}}, z_exp};

  fma_align #(.EI_W(EI_W)) u_align (
    .p_word(p_word), .p_exp(p_exp), .z_word(z_word), .z_exp(z_exp_w),
    .p_al(p_al), .z_al(z_al), .c_exp(c_exp),
    .p_moved(p_moved), .z_moved(z_moved)
  );

  fma_addnorm #(.EI_W(EI_W), .OUT_W(OUT_W)) u_addn (
    .p_sign(p_sign), .z_sign(z_sign), .p_al(p_al), .z_al(z_al),
    .c_exp(c_exp), .rm_down(rmode == fma_pkg::RM_DOWN),
    .r_sign(an_sign), .r_exp(an_exp), .r_sig(an_sig),
    .ev_carry(ev_carry), .ev_cancel(ev_cancel)
  );

  // Zero addend: the product passes alone.
  assign p_squeezed = fma_pkg::shr_jam(p_word, TAIL);
  assign nx_sign = z_is_zero ? p_sign : an_sign;
  assign nx_exp  = z_is_zero ? p_exp  : an_exp;
  assign nx_sig  = z_is_zero ? p_squeezed[OUT_W-1:0] : an_sig;

  assign in_ready    = !out_valid;
  assign accept      = in_valid && in_ready;
  assign release_res = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_sign  <= 1'b0;
      res_exp   <= '0;
      res_sig   <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        res_sign  <= nx_sign;
        res_exp   <= nx_exp;
        res_sig   <= nx_sig;
      end else if (release_res) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_sign)
      && $stable(res_exp) && $stable(res_sig));

  p_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && x_sig[SIG_W-1] && y_sig[SIG_W-1]
      |-> p_word[fma_pkg::LEAD] && !p_word[WORD_W-1]);

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !z_is_zero |-> !(p_moved && z_moved) && !p_al[WORD_W-1] && !z_al[WORD_W-1]);

  p_norm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && x_sig[SIG_W-1] && y_sig[SIG_W-1] && (z_is_zero || z_sig[SIG_W-1])
      |=> res_sig[OUT_W-1] || (res_sig == '0));

  p_zero_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (rmode != fma_pkg::RM_DOWN) |=> (res_sig != '0) || !res_sign);

endmodule

// File: tb/fma_sig_core_tb.sv
module fma_sig_core_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic x_sign = 0, y_sign = 0, z_sign = 0, z_is_zero = 0, neg_prod = 0;
  logic signed [9:0] x_exp = '0, y_exp = '0, z_exp = '0;
  logic [23:0] x_sig = 24'h800000, y_sig = 24'h800000, z_sig = 24'h800000;
  logic [1:0] rmode = 2'b00;
  logic res_sign;
  logic signed [11:0] res_exp;
  logic [26:0] res_sig;

  int n_checks = 0, n_errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  fma_sig_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x_sign(x_sign), .x_exp(x_exp), .x_sig(x_sig),
    .y_sign(y_sign), .y_exp(y_exp), .y_sig(y_sig),
    .z_sign(z_sign), .z_exp(z_exp), .z_sig(z_sig),
    .z_is_zero(z_is_zero), .neg_prod(neg_prod), .rmode(rmode),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_sign(res_sign), .res_exp(res_exp), .res_sig(res_sig)
  );

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  function automatic logic [63:0] jam1(input logic [63:0] v);
    return (v >> 1) | {63'b0, v[0]};
  endfunction

  // Bit-serial model of the requirements.
  task automatic model(output logic es, output int ee, output logic [26:0] em);
    logic [63:0] pw, zw, w;
    int pe, ze;
    logic ps;
    pw = (64'(x_sig) * 64'(y_sig)) << 16;
    pe = int'(x_exp) + int'(y_exp);
    ps = x_sign ^ y_sign ^ neg_prod;
    if (pw[63]) begin pw = pw >> 1; pe++; end
    if (z_is_zero) begin
      w = pw; es = ps;
    end else begin
      zw = 64'(z_sig) << 39;
      ze = int'(z_exp);
      while (pe < ze) begin pw = jam1(pw); pe++; end
      while (ze < pe) begin zw = jam1(zw); ze++; end
      if (ps == z_sign) begin
        w = zw + pw; es = z_sign;
        if (w[63]) begin w = jam1(w); pe++; end
      end else begin
        if (zw >= pw) begin w = zw - pw; es = z_sign; end
        else begin w = pw - zw; es = ps; end
        if (w == 64'd0) begin
          es = (rmode == 2'b11); ee = 0; em = '0;
          return;
        end
        while (!w[62]) begin w = w << 1; pe--; end
      end
    end
    for (int i = 0; i < 36; i++) w = jam1(w);
    ee = pe; em = w[26:0];
  endtask

  task automatic run_op(input string req);
    logic es; int ee; logic [26:0] em;
    model(es, ee, em);
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && res_sign == es && int'(res_exp) == ee && res_sig == em, req,
        $sformatf("v=%0b s=%0b e=%0d m=%07h", out_valid, res_sign, res_exp, res_sig),
        $sformatf("v=1 s=%0b e=%0d m=%07h", es, ee, em));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic logic [23:0] pat(input int i, input int k);
    case (i)
      0: return 24'h800000;
      1: return (k == 2) ? 24'hC00001 : 24'hFFFFFF;
      2: return (k == 0) ? 24'hABCDEF : (k == 1) ? 24'h912345 : 24'hFEDCBA;
      default: return (k == 0) ? 24'h800001 : (k == 1) ? 24'hFFFFFF : 24'h800003;
    endcase
  endfunction

  initial begin
    #(CLK_NS * 200000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && in_ready, "R1", $sformatf("v=%0b r=%0b", out_valid, in_ready), "v=0 r=1");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: hold while the consumer stalls; new offers are refused
    x_exp = 10'sd1; y_exp = 10'sd2; z_exp = 10'sd0;
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && !in_ready && res_sig[26], "R1",
        $sformatf("v=%0b r=%0b", out_valid, in_ready), "v=1 r=0");
    begin
      logic [26:0] held_sig; logic signed [11:0] held_exp;
      held_sig = res_sig; held_exp = res_exp;
      x_sig = 24'hFFFFFF; z_exp = -10'sd7;
      repeat (3) @(negedge clk);
      chk(out_valid && res_sig == held_sig && res_exp == held_exp, "R1",
          $sformatf("m=%07h e=%0d", res_sig, res_exp),
          $sformatf("m=%07h e=%0d", held_sig, held_exp));
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R1", $sformatf("v=%0b", out_valid), "v=0");

    // R2: product of two near-2 significands carries into bit 63
    x_sig = 24'hFFFFFF; y_sig = 24'hFFFFFF; x_exp = 10'sd5; y_exp = -10'sd3;
    x_sign = 0; y_sign = 0; neg_prod = 0; z_is_zero = 1;
    run_op("R2");
    chk(int'(res_exp) == 3, "R2", $sformatf("e=%0d", res_exp), "e=3");

    // R3 / R4: zero addend sweep over signs, negate flag and patterns
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 8; s++) begin
        x_sig = pat(p, 0); y_sig = pat(p, 1);
        x_sign = s[0]; y_sign = s[1]; neg_prod = s[2];
        x_exp = -10'sd100; y_exp = 10'sd37;
        run_op("R3");
        chk(res_sign == (s[0] ^ s[1] ^ s[2]), "R4",
            $sformatf("s=%0b", res_sign), $sformatf("s=%0b", s[0] ^ s[1] ^ s[2]));
      end
    z_is_zero = 0;

    // R5/R6/R7/R9/R10: sweep of exponent gaps, signs and patterns
    for (int d = -40; d <= 40; d++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 8; s++) begin
          x_sig = pat(p, 0); y_sig = pat(p, 1); z_sig = pat(p, 2);
          x_sign = s[0]; neg_prod = s[1]; z_sign = s[2]; y_sign = 0;
          x_exp = 10'sd3; y_exp = -10'sd5; z_exp = 10'(-2 + d);
          run_op((s[0] ^ s[1]) == s[2] ? "R6" : "R7");
        end

    // R5: gaps beyond the word width keep only the jammed bit
    x_sig = 24'h800001; y_sig = 24'hFFFFFF; z_sig = 24'hC00000;
    x_sign = 0; neg_prod = 0;
    for (int g = 0; g < 4; g++) begin
      x_exp = 10'sd0; y_exp = 10'sd0;
      z_exp = (g == 0) ? 10'sd100 : (g == 1) ? -10'sd100 : (g == 2) ? 10'sd63 : -10'sd300;
      z_sign = g[0];
      run_op("R5");
    end

    // R8: exact cancellation under every rounding mode
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 2; n++) begin
        x_sig = 24'h800000; y_sig = 24'h800000; z_sig = 24'h800000;
        x_sign = 0; y_sign = 0; neg_prod = n[0]; z_sign = ~n[0];
        x_exp = 10'sd4; y_exp = -10'sd1; z_exp = 10'sd3; rmode = 2'(m);
        run_op("R8");
        chk(res_sig == 0 && res_exp == 0 && res_sign == (m == 3), "R8",
            $sformatf("s=%0b e=%0d m=%07h", res_sign, res_exp, res_sig),
            $sformatf("s=%0b e=0 m=0", m == 3));
      end
    rmode = 2'b00;

    // R9: deep cancellation needs a long left shift
    x_sig = 24'h800000; y_sig = 24'h800000; z_sig = 24'h800001;
    x_sign = 0; y_sign = 0; neg_prod = 0; z_sign = 1;
    x_exp = 10'sd0; y_exp = 10'sd0; z_exp = 10'sd0;
    run_op("R9");
    chk(res_sign && int'(res_exp) == -23 && res_sig == 27'h4000000, "R9",
        $sformatf("s=%0b e=%0d m=%07h", res_sign, res_exp, res_sig), "s=1 e=-23 m=4000000");

    // R10: sticky bit set by discarded product bits
    x_sig = 24'h800001; y_sig = 24'h800001; z_is_zero = 1;
    run_op("R10");
    chk(res_sig[0] == 1'b1, "R10", $sformatf("m=%07h", res_sig), "bit0=1");
    z_is_zero = 0;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule